// File: doc/BRIEF.md
# Trigger Arm and Holdoff Controller

This block sits between the trigger detection logic and the capture engine of a sampling instrument. It receives a one-cycle pulse whenever the detection logic sees a qualifying condition. It decides whether that pulse is accepted as the trigger for an acquisition, or ignored because the controller is idle, in holdoff, or still waiting for the previous capture to finish. Every accepted trigger is reported as a strobe. A second strobe follows after a programmable delay, and it marks where the post-trigger part of the capture begins.

Four arming modes exist:
- Free-running with a timeout that forces a trigger when the input stays quiet.
- Strictly event-driven.
- Stop after one acquisition.
- Stop after a programmed number of acquisitions.

Holdoff, delay and timeout are counted in clock ticks and are wide enough to span seconds. A separate registered path turns a record length and a position in whole percent into the number of samples the capture memory keeps ahead of the trigger.

Top module: `trig_arm_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the controller is idle. `armed_o`, `trig_acc_o`, `trig_forced_o`, `trig_dly_o`, `done_o` and `pretrig_o` are all zero.
- R2: A `start_i` pulse in the idle state arms the controller on the next cycle. An event pulse seen while armed produces `trig_acc_o` high for exactly one cycle, on the cycle after the event.
- R3: After each accepted trigger, events are ignored for `max(holdoff_i, HOLDOFF_MIN)` cycles. With events held high and `acq_done_i` held high, accepted strobes are `max(holdoff_i, HOLDOFF_MIN)+1` cycles apart. Re-arming also waits for an `acq_done_i` pulse received after the accept. The cycle after that pulse is an armed cycle.
- R4: `trig_dly_o` pulses for one cycle, `delay_i` cycles after the matching `trig_acc_o`. When `delay_i` is 0, it pulses in the same cycle as `trig_acc_o`.
- R5: In auto mode (`mode_i` = 2'b00), after T armed cycles without an event, the controller forces a trigger: `trig_acc_o` and `trig_forced_o` are both high. T is `auto_tmo_i`, and a value of 0 is treated as 1. The timeout restarts at every re-arm. A real event accepted in auto mode leaves `trig_forced_o` low.
- R6: In normal mode (`mode_i` = 2'b01), no trigger is ever produced without an event, however long the controller stays armed.
- R7: In single mode (`mode_i` = 2'b10), the controller accepts exactly one trigger. It then goes idle and raises `done_o`, which stays high until the next `start_i`.
- R8: In counted mode (`mode_i` = 2'b11), the controller accepts `nacq_i` triggers (0 is treated as 1), then goes idle with `done_o` high.
- R9: `stop_i` takes priority over everything else. It makes the controller idle on the next cycle, clears the counted-mode tally, and cancels any pending `trig_dly_o`.
- R10: `pretrig_o` equals `rec_len_i * min(pos_pct_i, 100) / 100`, rounded down. It is registered one cycle after the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Arm command pulse |
| stop_i | input | 1 | Abort command pulse |
| mode_i | input | 2 | 00 auto, 01 normal, 10 single, 11 counted |
| nacq_i | input | N_W | Acquisitions in counted mode |
| holdoff_i | input | CNT_W | Holdoff in clock ticks |
| delay_i | input | CNT_W | Trigger delay in clock ticks |
| auto_tmo_i | input | CNT_W | Auto-mode timeout in clock ticks |
| rec_len_i | input | REC_W | Record length in samples |
| pos_pct_i | input | PCT_W | Trigger position in percent |
| trig_evt_i | input | 1 | Trigger event pulse from detection logic |
| acq_done_i | input | 1 | Capture-finished strobe |
| armed_o | output | 1 | Controller is waiting for an event |
| trig_acc_o | output | 1 | Accepted trigger strobe |
| trig_forced_o | output | 1 | Accepted trigger was forced by timeout |
| trig_dly_o | output | 1 | Delayed trigger strobe |
| done_o | output | 1 | Single or counted run finished |
| pretrig_o | output | REC_W | Pre-trigger sample count |

## Verification
On every cycle, the assertions check the following:
- A stop leaves the controller idle and without a strobe.
- An accept strobe never lasts two cycles.
- A forced strobe only appears with an accept strobe, and only in auto mode.
- A finished run is never armed.
- A holdoff is never reloaded before the previous one expires.
- A zero delay yields an immediate delayed strobe.
- The pre-trigger count never exceeds the record length.

The exact holdoff spacing, the gating on the capture-finished strobe, the timeout length, the acquisition counts in the stopping modes and the cancelled delayed strobe after a stop all depend on the stimulus history. Only the bench scenarios, which measure cycle distances between strobes, can show them.

// File: rtl/trig_arm_pkg.sv
package trig_arm_pkg;
  typedef enum logic [1:0] {
    MODE_AUTO     = 2'b00,
    MODE_NORMAL   = 2'b01,
    MODE_SINGLE   = 2'b10,
    MODE_SINGLE_N = 2'b11
  } arm_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ARMED = 2'b01,
    ST_HOLD  = 2'b10
  } arm_state_e;
endpackage

// File: rtl/trig_holdoff.sv
module trig_holdoff #(
  parameter int CNT_W     = 32,
  parameter int MIN_TICKS = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] hold_i,
  output logic             expired_o
);
  localparam logic [CNT_W-1:0] MIN_L = CNT_W'(MIN_TICKS);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] eff;

  // floor the programmed value at the minimum holdoff
  always_comb eff = (hold_i < MIN_L) ? MIN_L : hold_i;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cnt <= '0;
    end else if (load_i) begin
      cnt <= eff;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  // last holdoff cycle is reached when one tick remains
  assign expired_o = (cnt <= CNT_W'(1));

  // R3: a new holdoff never starts while the previous one runs
  p_reload_after_expiry_r3: assert property (@(posedge clk) disable iff (rst)
    load_i |-> expired_o);
endmodule

// File: rtl/trig_delay.sv
module trig_delay #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] delay_i,
  output logic             strobe_o
);
  logic [CNT_W-1:0] cnt;
  logic             busy;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cnt      <= '0;
      busy     <= 1'b0;
      strobe_o <= 1'b0;
    end else begin
      strobe_o <= 1'b0;
      if (start_i) begin
        if (delay_i == '0) begin
          strobe_o <= 1'b1;
          busy     <= 1'b0;
        end else begin
          cnt  <= delay_i;
          busy <= 1'b1;
        end
      end else if (busy) begin
        if (cnt == CNT_W'(1)) begin
          strobe_o <= 1'b1;
          busy     <= 1'b0;
        end
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R4: zero delay fires alongside the accept strobe
  p_zero_delay_r4: assert property (@(posedge clk) disable iff (rst)
    (start_i && !clear_i && delay_i == '0) |=> strobe_o);
endmodule

// File: rtl/trig_pos_calc.sv
module trig_pos_calc #(
  parameter int REC_W = 16,
  parameter int PCT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REC_W-1:0] rec_len_i,
  input  logic [PCT_W-1:0] pct_i,
  output logic [REC_W-1:0] pretrig_o
);
  localparam int PROD_W = REC_W + PCT_W;
  localparam logic [PCT_W-1:0] FULL = PCT_W'(100);

  logic [PCT_W-1:0]  pct_c;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quo;

  always_comb begin
    pct_c = (pct_i > FULL) ? FULL : pct_i;
    prod  = PROD_W'(rec_len_i) * PROD_W'(pct_c);
    quo   = prod / PROD_W'(100);
  end

  always_ff @(posedge clk) begin
    if (rst) pretrig_o <= '0;
    else     pretrig_o <= quo[REC_W-1:0];
  end

  // R10: pre-trigger share never exceeds the record
  p_pos_bound_r10: assert property (@(posedge clk) disable iff (rst)
    pretrig_o <= $past(rec_len_i));
endmodule

// File: rtl/trig_arm_ctrl.sv
module trig_arm_ctrl
  import trig_arm_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int HOLDOFF_MIN = 20,
  parameter int REC_W       = 16,
  parameter int PCT_W       = 7,
  parameter int N_W         = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [1:0]       mode_i,
  input  logic [N_W-1:0]   nacq_i,
  input  logic [CNT_W-1:0] holdoff_i,
  input  logic [CNT_W-1:0] delay_i,
  input  logic [CNT_W-1:0] auto_tmo_i,
  input  logic [REC_W-1:0] rec_len_i,
  input  logic [PCT_W-1:0] pos_pct_i,
  input  logic             trig_evt_i,
  input  logic             acq_done_i,
  output logic             armed_o,
  output logic             trig_acc_o,
  output logic             trig_forced_o,
  output logic             trig_dly_o,
  output logic             done_o,
  output logic [REC_W-1:0] pretrig_o
);
  localparam logic [N_W-1:0] N_MAX = {N_W{1'b1}};

  arm_state_e       state;
  arm_mode_e        mode;
  logic [CNT_W-1:0] tmo_cnt;
  logic [CNT_W-1:0] tmo_eff;
  logic [N_W-1:0]   acc_cnt;
  logic [N_W-1:0]   n_eff;
  logic             acq_seen;
  logic             hold_expired;
  logic             tmo_hit;
  logic             accept_real;
  logic             accept_force;
  logic             accept;
  logic             rearm_ok;
  logic             last_run;

  always_comb begin
    mode         = arm_mode_e'(mode_i);
    n_eff        = (nacq_i == '0) ? N_W'(1) : nacq_i;
    tmo_eff      = (auto_tmo_i == '0) ? CNT_W'(1) : auto_tmo_i;
    tmo_hit      = (mode == MODE_AUTO) && (tmo_cnt >= tmo_eff - 1'b1);
    accept_real  = (state == ST_ARMED) && trig_evt_i && !stop_i;
    accept_force = (state == ST_ARMED) && !trig_evt_i && tmo_hit && !stop_i;
    accept       = accept_real || accept_force;
    rearm_ok     = (state == ST_HOLD) && hold_expired &&
                   (acq_seen || acq_done_i) && !stop_i;
    last_run     = (mode == MODE_SINGLE) ||
                   ((mode == MODE_SINGLE_N) && (acc_cnt >= n_eff));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      tmo_cnt       <= '0;
      acc_cnt       <= '0;
      acq_seen      <= 1'b0;
      trig_acc_o    <= 1'b0;
      trig_forced_o <= 1'b0;
      done_o        <= 1'b0;
    end else begin
      trig_acc_o    <= accept;
      trig_forced_o <= accept_force;
      if (stop_i) begin
        state    <= ST_IDLE;
        tmo_cnt  <= '0;
        acc_cnt  <= '0;
        acq_seen <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (start_i) begin
              state   <= ST_ARMED;
              tmo_cnt <= '0;
              acc_cnt <= '0;
              done_o  <= 1'b0;
            end
          end
          ST_ARMED: begin
            if (accept) begin
              state    <= ST_HOLD;
              acq_seen <= 1'b0;
              tmo_cnt  <= '0;
              if (mode != MODE_AUTO && mode != MODE_NORMAL && acc_cnt != N_MAX)
                acc_cnt <= acc_cnt + 1'b1;
            end else if (mode == MODE_AUTO) begin
              tmo_cnt <= tmo_cnt + 1'b1;
            end
          end
          ST_HOLD: begin
            if (acq_done_i) acq_seen <= 1'b1;
            if (rearm_ok) begin
              if (last_run) begin
                state  <= ST_IDLE;
                done_o <= 1'b1;
              end else begin
                state   <= ST_ARMED;
                tmo_cnt <= '0;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign armed_o = (state == ST_ARMED);

  trig_holdoff #(.CNT_W(CNT_W), .MIN_TICKS(HOLDOFF_MIN)) u_holdoff (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (stop_i),
    .load_i    (accept),
    .hold_i    (holdoff_i),
    .expired_o (hold_expired)
  );

  trig_delay #(.CNT_W(CNT_W)) u_delay (
    .clk      (clk),
    .rst      (rst),
    .clear_i  (stop_i),
    .start_i  (accept),
    .delay_i  (delay_i),
    .strobe_o (trig_dly_o)
  );

  trig_pos_calc #(.REC_W(REC_W), .PCT_W(PCT_W)) u_pos (
    .clk       (clk),
    .rst       (rst),
    .rec_len_i (rec_len_i),
    .pct_i     (pos_pct_i),
    .pretrig_o (pretrig_o)
  );

  // R9: stop leaves the block idle with no strobe
  p_stop_idle_r9: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> (!armed_o && !trig_acc_o));
  // R2: accept strobe is a single-cycle pulse
  p_acc_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    trig_acc_o |=> !trig_acc_o);
  // R5: forced strobe always accompanies an accept
  p_forced_is_acc_r5: assert property (@(posedge clk) disable iff (rst)
    trig_forced_o |-> trig_acc_o);
  // R6: forcing only occurs in auto mode
  p_no_force_outside_auto_r6: assert property (@(posedge clk) disable iff (rst)
    trig_forced_o |-> ($past(mode_i) == 2'b00));
  // R7: a finished run is never armed
  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !armed_o);
endmodule

// File: tb/trig_arm_ctrl_tb.sv
module trig_arm_ctrl_tb;
  localparam int CNT_W = 32;
  localparam int HMIN  = 20;
  localparam int REC_W = 16;
  localparam int PCT_W = 7;
  localparam int N_W   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, stop_i = 1'b0;
  logic [1:0] mode_i = 2'b01;
  logic [N_W-1:0] nacq_i = '0;
  logic [CNT_W-1:0] holdoff_i = '0, delay_i = '0, auto_tmo_i = '0;
  logic [REC_W-1:0] rec_len_i = '0;
  logic [PCT_W-1:0] pos_pct_i = '0;
  logic trig_evt_i = 1'b0, acq_done_i = 1'b0;
  logic armed_o, trig_acc_o, trig_forced_o, trig_dly_o, done_o;
  logic [REC_W-1:0] pretrig_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  trig_arm_ctrl #(.CNT_W(CNT_W), .HOLDOFF_MIN(HMIN), .REC_W(REC_W),
                  .PCT_W(PCT_W), .N_W(N_W)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
    .mode_i(mode_i), .nacq_i(nacq_i), .holdoff_i(holdoff_i),
    .delay_i(delay_i), .auto_tmo_i(auto_tmo_i), .rec_len_i(rec_len_i),
    .pos_pct_i(pos_pct_i), .trig_evt_i(trig_evt_i), .acq_done_i(acq_done_i),
    .armed_o(armed_o), .trig_acc_o(trig_acc_o), .trig_forced_o(trig_forced_o),
    .trig_dly_o(trig_dly_o), .done_o(done_o), .pretrig_o(pretrig_o)
  );

  function automatic longint exp_gap(longint h);
    return ((h < HMIN) ? HMIN : h) + 1;
  endfunction

  function automatic longint exp_pre(longint rec, longint pct);
    return rec * ((pct > 100) ? 100 : pct) / 100;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_eq(input string req, input longint act, input longint exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic do_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk) stop_i = 1'b1;
    @(negedge clk) stop_i = 1'b0;
  endtask

  task automatic wait_acc(input int limit, output int n, output bit forced);
    bit seen = 1'b0;
    n = 0;
    forced = 1'b0;
    while (!seen && n < limit) begin
      @(negedge clk);
      n++;
      if (trig_acc_o) begin
        seen = 1'b1;
        forced = trig_forced_o;
      end
    end
    if (!seen) n = -1;
  endtask

  task automatic count_acc(input int cycles, output int c);
    c = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (trig_acc_o) c++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n, c;
    bit f;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    expect_eq("R1 armed", armed_o, 0);
    expect_eq("R1 acc", trig_acc_o, 0);
    expect_eq("R1 dly", trig_dly_o, 0);
    expect_eq("R1 done", done_o, 0);
    expect_eq("R1 pretrig", pretrig_o, 0);

    // R2 basic accept, R4 zero delay
    mode_i = 2'b01; holdoff_i = 30; delay_i = 0; acq_done_i = 1'b1;
    do_start();
    expect_eq("R2 armed after start", armed_o, 1);
    @(negedge clk) trig_evt_i = 1'b1;
    @(negedge clk) trig_evt_i = 1'b0;
    expect_eq("R2 acc strobe", trig_acc_o, 1);
    expect_eq("R2 not forced", trig_forced_o, 0);
    expect_eq("R4 zero delay same cycle", trig_dly_o, 1);
    @(negedge clk);
    expect_eq("R2 acc one cycle", trig_acc_o, 0);

    // R3 holdoff spacing, directed and random
    trig_evt_i = 1'b1;
    wait_acc(1000, n, f);
    wait_acc(1000, n, f);
    expect_eq("R3 gap H=30", n, exp_gap(30));
    holdoff_i = 5;
    wait_acc(1000, n, f);
    wait_acc(1000, n, f);
    expect_eq("R3 gap clamped", n, exp_gap(5));
    for (int k = 0; k < 4; k++) begin
      longint h = 20 + ($urandom % 300);
      holdoff_i = CNT_W'(h);
      wait_acc(1000, n, f);
      wait_acc(1000, n, f);
      expect_eq("R3 gap random", n, exp_gap(h));
    end
    do_stop();
    expect_eq("R9 idle after stop", armed_o, 0);

    // R3 acquisition-done gating
    holdoff_i = 20; acq_done_i = 1'b0; trig_evt_i = 1'b1;
    do_start();
    wait_acc(10, n, f);
    expect_eq("R3 first accept", n, 1);
    count_acc(100, c);
    expect_eq("R3 held until acq done", c, 0);
    @(negedge clk) acq_done_i = 1'b1;
    @(negedge clk) acq_done_i = 1'b0;
    expect_eq("R3 rearm cycle", trig_acc_o, 0);
    @(negedge clk);
    expect_eq("R3 accept after acq done", trig_acc_o, 1);
    do_stop();
    trig_evt_i = 1'b0; acq_done_i = 1'b1;

    // R4 nonzero delays
    for (int k = 0; k < 3; k++) begin
      int d = (k == 0) ? 7 : 1 + int'($urandom % 60);
      delay_i = CNT_W'(d);
      do_start();
      @(negedge clk) trig_evt_i = 1'b1;
      @(negedge clk) trig_evt_i = 1'b0;
      n = 0;
      while (!trig_dly_o && n < 200) begin
        @(negedge clk);
        n++;
      end
      expect_eq("R4 delay distance", n, d);
      do_stop();
    end
    delay_i = 0;

    // R5 auto timeout
    mode_i = 2'b00; auto_tmo_i = 50; holdoff_i = 20; trig_evt_i = 1'b0;
    do_start();
    wait_acc(500, n, f);
    expect_eq("R5 timeout length", n, 50);
    expect_eq("R5 forced flag", f, 1);
    wait_acc(500, n, f);
    expect_eq("R5 timeout after rearm", n, 70);
    trig_evt_i = 1'b1;
    wait_acc(500, n, f);
    expect_eq("R5 real event gap", n, exp_gap(20));
    expect_eq("R5 real not forced", f, 0);
    do_stop();
    trig_evt_i = 1'b0; auto_tmo_i = 0;
    do_start();
    wait_acc(500, n, f);
    expect_eq("R5 zero timeout as one", n, 1);
    do_stop();

    // R6 normal never forces
    mode_i = 2'b01;
    do_start();
    count_acc(500, c);
    expect_eq("R6 no forced trigger", c, 0);
    expect_eq("R6 still armed", armed_o, 1);
    do_stop();

    // R7 single
    mode_i = 2'b10; trig_evt_i = 1'b1;
    do_start();
    count_acc(200, c);
    expect_eq("R7 one accept", c, 1);
    expect_eq("R7 done", done_o, 1);
    expect_eq("R7 idle", armed_o, 0);
    do_start();
    expect_eq("R7 done cleared by start", done_o, 0);
    do_stop();

    // R8 counted
    mode_i = 2'b11; nacq_i = 3;
    do_start();
    count_acc(300, c);
    expect_eq("R8 three accepts", c, 3);
    expect_eq("R8 done", done_o, 1);
    nacq_i = 0;
    do_start();
    count_acc(200, c);
    expect_eq("R8 zero as one", c, 1);

    // R9 stop cancels delay, clears tally
    mode_i = 2'b01; trig_evt_i = 1'b0; delay_i = 40;
    do_start();
    @(negedge clk) trig_evt_i = 1'b1;
    @(negedge clk) trig_evt_i = 1'b0;
    repeat (5) @(negedge clk);
    do_stop();
    c = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (trig_dly_o) c++;
    end
    expect_eq("R9 delayed strobe cancelled", c, 0);
    delay_i = 0; mode_i = 2'b11; nacq_i = 3; trig_evt_i = 1'b1;
    do_start();
    wait_acc(20, n, f);
    do_stop();
    do_start();
    count_acc(300, c);
    expect_eq("R9 tally cleared", c, 3);
    trig_evt_i = 1'b0;

    // R10 trigger position
    for (int k = 0; k < 24; k++) begin
      longint r, p;
      case (k)
        0: begin r = 1000;  p = 0;   end
        1: begin r = 1000;  p = 100; end
        2: begin r = 999;   p = 127; end
        3: begin r = 65535; p = 99;  end
        default: begin r = $urandom % 65536; p = $urandom % 128; end
      endcase
      @(negedge clk);
      rec_len_i = REC_W'(r);
      pos_pct_i = PCT_W'(p);
      @(negedge clk);
      expect_eq("R10 pretrig", pretrig_o, exp_pre(r, p));
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule